// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding and Load Interlock

This block is the hazard control for a five-stage in-order integer pipeline whose operands are forwarded into the decode stage. Each cycle it looks at the two source registers that the instruction in decode reads. It compares each one against the destination register and write flag of the instructions now in the execute, memory and write-back stages. From that comparison it chooses, for each source, whether the datapath takes the register file value or one of three forwarded results.

One case cannot be forwarded in time: a load in execute whose destination feeds a source read in decode. The block then asks the pipeline to stop for one cycle. The fetch address and the fetch/decode register hold, and a bubble goes into execute. On the next cycle the load sits in the memory stage, and its value arrives over the memory forwarding path.

A three-bit configuration input can switch off any forwarding path. When the youngest matching producer sits on a switched-off path, the block stalls instead of falling back to an older value. This makes it possible to measure the stall cost of a pipeline that lacks that path.

Top module: `dec_bypass`

## Requirements
- R1: A source selects the execute path (select code 1) when it is read, it is not register 0, the execute instruction writes a register, and the execute destination equals the source.
- R2: The same match against the memory stage gives select code 2, and against write-back gives code 3. With no usable match the select is 0 (register file).
- R3: When several stages match, the youngest wins: execute over memory, and memory over write-back.
- R4: A load in execute (load flag high) whose destination matches a read source raises the stall output, and that source's select is 0 in the same cycle.
- R5: Source register 0 never matches, so it causes neither forwarding nor stall.
- R6: A source whose read-enable is low causes neither forwarding nor stall.
- R7: The two sources are resolved independently. The stall output is high when either source needs a stall.
- R8: The fetch-hold, decode-hold and execute-bubble outputs are each high exactly when the stall output is high.
- R9: Disable bits are bit 0 execute, bit 1 memory, bit 2 write-back. If the youngest matching stage's path is disabled, the block stalls and that source's select is 0. A disabled older path does not affect a younger enabled match.
- R10: A load in the memory stage that matches a source is forwarded with select code 2 and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | RW | First source register number in decode |
| rd_a | input | 1 | First source is read |
| src_b | input | RW | Second source register number in decode |
| rd_b | input | 1 | Second source is read |
| ex_dst | input | RW | Destination register of the execute instruction |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_ld | input | 1 | Execute instruction is a load |
| mem_dst | input | RW | Destination register in the memory stage |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | RW | Destination register in write-back |
| wb_wr | input | 1 | Write-back instruction writes a register |
| path_off | input | 3 | Per-path forwarding disable (bit 0 execute, 1 memory, 2 write-back) |
| sel_a | output | 2 | First operand source select |
| sel_b | output | 2 | Second operand source select |
| stall | output | 1 | Interlock request |
| pc_hold | output | 1 | Hold the fetch address |
| ifid_hold | output | 1 | Hold the fetch/decode register |
| ex_bubble | output | 1 | Clear the write flag entering execute |

## Verification
The embedded checks act on every evaluation of the decode logic. Each execute-path select must come from a real, enabled, non-load execute match. Register 0 and unread sources must always give select 0. A matching load in execute must always produce a stall, and a memory-path select must never hide a younger execute match or use a disabled path. Only the bench scenarios can show the priority order across stages in a concrete instruction mix. They also show the cycle after a load-use stall, where the load value is picked up from the memory stage, and the combined effect when one source stalls while the other is forwarded.

// File: rtl/dec_bypass.sv
module dec_bypass #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] src_a,
  input  logic          rd_a,
  input  logic [RW-1:0] src_b,
  input  logic          rd_b,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_wr,
  input  logic          ex_ld,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wr,
  input  logic [2:0]    path_off,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic          stall,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          ex_bubble
);

  localparam logic [1:0] S_RF  = 2'd0;
  localparam logic [1:0] S_EX  = 2'd1;
  localparam logic [1:0] S_MEM = 2'd2;
  localparam logic [1:0] S_WB  = 2'd3;

  logic [RW-1:0] src [2];
  logic          rd  [2];
  logic [1:0]    sel [2];
  logic [1:0]    blk;

  assign src[0] = src_a;
  assign src[1] = src_b;
  assign rd[0]  = rd_a;
  assign rd[1]  = rd_b;

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic live, hit_ex, hit_mem, hit_wb;

    assign live    = rd[p] && (src[p] != '0);
    assign hit_ex  = live && ex_wr  && (ex_dst  == src[p]);
    assign hit_mem = live && mem_wr && (mem_dst == src[p]);
    assign hit_wb  = live && wb_wr  && (wb_dst  == src[p]);

    assign blk[p] = hit_ex  ? (ex_ld || path_off[0]) :
                    hit_mem ? path_off[1] :
                    hit_wb  ? path_off[2] : 1'b0;

    assign sel[p] = blk[p]  ? S_RF  :
                    hit_ex  ? S_EX  :
                    hit_mem ? S_MEM :
                    hit_wb  ? S_WB  : S_RF;

    always_comb begin
      if (!$isunknown({src[p], rd[p], ex_dst, ex_wr, ex_ld, mem_dst, mem_wr,
                       wb_dst, wb_wr, path_off})) begin
        if (sel[p] == S_EX)
          p_ex_pick_r1: assert (rd[p] && ex_wr && ex_dst == src[p] && !ex_ld && !path_off[0])
            else $error("execute select without a usable execute match");
        if (src[p] == '0)
          p_zero_src_r5: assert (sel[p] == S_RF)
            else $error("register 0 forwarded");
        if (!rd[p])
          p_unread_r6: assert (sel[p] == S_RF)
            else $error("unread source forwarded");
        if (rd[p] && src[p] != '0 && ex_wr && ex_ld && ex_dst == src[p])
          p_load_use_r4: assert (stall && sel[p] == S_RF)
            else $error("load-use not interlocked");
        if (sel[p] == S_MEM)
          p_mem_pick_r9: assert (!path_off[1] && !(ex_wr && ex_dst == src[p]))
            else $error("memory select hides younger match or disabled path");
      end
    end
  end

  assign sel_a     = sel[0];
  assign sel_b     = sel[1];
  assign stall     = |blk;
  assign pc_hold   = stall;
  assign ifid_hold = stall;
  assign ex_bubble = stall;

endmodule

// File: tb/dec_bypass_tb.sv
module dec_bypass_tb;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [RW-1:0] src_a, src_b, ex_dst, mem_dst, wb_dst;
  logic rd_a, rd_b, ex_wr, ex_ld, mem_wr, wb_wr;
  logic [2:0] path_off;
  logic [1:0] sel_a, sel_b;
  logic stall, pc_hold, ifid_hold, ex_bubble;

  dec_bypass #(.RW(RW)) u_dut (
    .src_a(src_a), .rd_a(rd_a), .src_b(src_b), .rd_b(rd_b),
    .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_ld(ex_ld),
    .mem_dst(mem_dst), .mem_wr(mem_wr), .wb_dst(wb_dst), .wb_wr(wb_wr),
    .path_off(path_off), .sel_a(sel_a), .sel_b(sel_b), .stall(stall),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .ex_bubble(ex_bubble)
  );

  typedef struct {
    logic [1:0] ea;
    logic [1:0] eb;
    logic       es;
    string      tag;
  } exp_t;

  exp_t q[$];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic drive(input int sa, input bit ra, input int sb, input bit rb,
                       input int ed, input bit ew, input bit el,
                       input int md, input bit mw, input int wd, input bit ww,
                       input logic [2:0] off);
    src_a = RW'(sa); rd_a = ra; src_b = RW'(sb); rd_b = rb;
    ex_dst = RW'(ed); ex_wr = ew; ex_ld = el;
    mem_dst = RW'(md); mem_wr = mw; wb_dst = RW'(wd); wb_wr = ww;
    path_off = off;
  endtask

  task automatic push(input logic [1:0] ea, input logic [1:0] eb, input logic es,
                      input string tag);
    exp_t e;
    e.ea = ea; e.eb = eb; e.es = es; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input int sa, input bit ra, input int sb, input bit rb,
                      input int ed, input bit ew, input bit el,
                      input int md, input bit mw, input int wd, input bit ww,
                      input logic [2:0] off,
                      input logic [1:0] ea, input logic [1:0] eb, input logic es,
                      input string tag);
    @(posedge clk);
    #1;
    drive(sa, ra, sb, rb, ed, ew, el, md, mw, wd, ww, off);
    push(ea, eb, es, tag);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (sel_a !== e.ea || sel_b !== e.eb || stall !== e.es) begin
        errors++;
        $display("FAIL %s: sel_a=%0d sel_b=%0d stall=%0b expected %0d %0d %0b",
                 e.tag, sel_a, sel_b, stall, e.ea, e.eb, e.es);
      end
      checks++;
      if (pc_hold !== e.es || ifid_hold !== e.es || ex_bubble !== e.es) begin
        errors++;
        $display("FAIL R8 (%s): holds=%0b%0b%0b expected %0b",
                 e.tag, pc_hold, ifid_hold, ex_bubble, e.es);
      end
    end
  end

  initial begin
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3'b000);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle after reset: nothing read, nothing forwarded
    step(0,0, 0,0, 0,0,0, 0,0, 0,0, 3'b000, 0,0,0, "reset idle R6");
    step(3,1, 0,0, 3,1,0, 0,0, 0,0, 3'b000, 1,0,0, "R1 execute match");
    step(3,1, 0,0, 3,0,0, 0,0, 0,0, 3'b000, 0,0,0, "R1 execute not writing");
    step(0,0, 4,1, 0,0,0, 4,1, 0,0, 3'b000, 0,2,0, "R2 memory match on b");
    step(7,1, 0,0, 0,0,0, 0,0, 7,1, 3'b000, 3,0,0, "R2 write-back match");
    step(5,1, 0,0, 5,1,0, 5,1, 5,1, 3'b000, 1,0,0, "R3 all stages match");
    step(5,1, 0,0, 6,1,0, 5,1, 5,1, 3'b000, 2,0,0, "R3 memory over write-back");
    step(9,1, 0,0, 9,1,1, 0,0, 0,0, 3'b000, 0,0,1, "R4 load-use stall");
    // next cycle: bubble in execute, load now in memory
    step(9,1, 0,0, 9,0,0, 9,1, 0,0, 3'b000, 2,0,0, "R10 load picked from memory");
    step(0,1, 0,1, 0,1,1, 0,1, 0,1, 3'b000, 0,0,0, "R5 register 0");
    step(9,0, 9,0, 9,1,1, 9,1, 9,1, 3'b000, 0,0,0, "R6 read-enable low");
    step(2,1, 9,1, 9,1,1, 0,0, 2,1, 3'b000, 3,0,1, "R7 b stalls, a forwards");
    step(8,1, 8,1, 8,1,0, 0,0, 0,0, 3'b000, 1,1,0, "R7 both ports same source");
    step(3,1, 0,0, 3,1,0, 3,1, 0,0, 3'b001, 0,0,1, "R9 execute path off");
    step(4,1, 0,0, 0,0,0, 4,1, 0,0, 3'b010, 0,0,1, "R9 memory path off");
    step(4,1, 0,0, 0,0,0, 0,0, 4,1, 3'b100, 0,0,1, "R9 write-back path off");
    step(4,1, 0,0, 4,1,0, 0,0, 4,1, 3'b100, 1,0,0, "R9 older off, younger used");
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule